// File: doc/BRIEF.md
# Register File Toggle Energy Monitor

This block sits next to a multi-ported register file and keeps a running energy estimate built from bit activity, not from access counts. Each read port has an enable and the word being read. The monitor keeps the last word seen on each port. The read cost of a port is the number of bits that differ between the new word and the stored word, times a per-bit read cost.

Each write port has an enable, the word being written and the word it replaces. The replaced word is fetched by the surrounding logic and arrives as an input. The write cost is the number of differing bits between those two words, times a per-bit write cost.

Every cycle a fixed base cost is charged, even with no accesses. The read and write costs of all ports are added to it, and the total goes into a wide accumulator. The popcount and the weighting are split over two register stages. Activity sampled at a clock edge therefore reaches the accumulator two edges later.

Top module: `rf_toggle_energy_monitor`

## Requirements
- R1: While reset is asserted the accumulator output reads 0. Reset also clears every stored last-read word to 0, so the first enabled read after reset is charged against an all-zero word.
- R2: Every clock edge after the internal reset is released adds BASE_COST (default 5) to the accumulator, with or without accesses.
- R3: An enabled read on port i adds RD_BIT_COST (default 3) times the Hamming distance between rd_data word i and the last word stored for that port. The stored word then becomes the new value.
- R4: A disabled read port adds no energy and leaves its stored word unchanged, whatever its data input carries.
- R5: An enabled write on port j adds WR_BIT_COST (default 7) times the Hamming distance between wr_new word j and wr_old word j. Equal words cost nothing beyond the base.
- R6: A disabled write port adds no energy.
- R7: The contributions of all read ports and all write ports in one cycle are summed. Port i occupies bits [32*i+31 : 32*i] of each flat data bus.
- R8: Activity sampled at edge k changes the accumulator at edge k+2. Edges k and k+1 add only their own base cost and older activity.
- R9: rst_ni asserts asynchronously. Its release takes effect after two rising edges, and only the edges after that add energy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_en | input | NRD | Per read port access enable |
| rd_data | input | NRD*32 | Words read, port i in slice i |
| wr_en | input | NWR | Per write port access enable |
| wr_new | input | NWR*32 | Words being written |
| wr_old | input | NWR*32 | Previous contents of each written location |
| energy_acc | output | ACC_W | Running energy total, in cost units |

## Verification
The assertions assume that the enables are known, 0 or 1, on every sampled edge. They also assume that the total over a run stays far below 2^ACC_W. Only then does each step between consecutive edges keep at least the base cost, which the floor check relies on.

The stimulus drives fully defined enables and data on every cycle. Its runs are a few hundred cycles long, which keeps the total many orders of magnitude below the accumulator range.

// File: rtl/rte_pkg.sv
package rte_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  function automatic cnt_t ones(word_t w);
    cnt_t c;
    c = '0;
    for (int b = 0; b < WORD_W; b++) c = c + cnt_t'(w[b]);
    return c;
  endfunction
endpackage

// File: rtl/rte_rst_sync.sv
module rte_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/rte_rd_lane.sv
module rte_rd_lane
  import rte_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  en,
  input  word_t data,
  output cnt_t  cnt
);
  word_t prev_q, prev_d;
  cnt_t  cnt_q, cnt_d;

  always_comb begin
    prev_d = prev_q;
    cnt_d  = '0;
    if (en) begin
      prev_d = data;
      cnt_d  = ones(data ^ prev_q);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  a_r3_prev_load: assert property (@(posedge clk) disable iff (!rst_ni)
    en |=> (prev_q == $past(data)));
  a_r4_prev_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |=> $stable(prev_q));
  a_r4_no_read_cost: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/rte_wr_lane.sv
module rte_wr_lane
  import rte_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  en,
  input  word_t new_w,
  input  word_t old_w,
  output cnt_t  cnt
);
  cnt_t cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (en) cnt_d = ones(new_w ^ old_w);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  a_r6_no_write_cost: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |=> (cnt_q == '0));
  a_r5_same_word_free: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && (new_w == old_w)) |=> (cnt_q == '0));
endmodule

// File: rtl/rte_accum.sv
module rte_accum
  import rte_pkg::*;
#(
  parameter int          NRD         = 8,
  parameter int          NWR         = 4,
  parameter int          ACC_W       = 48,
  parameter int unsigned BASE_COST   = 5,
  parameter int unsigned RD_BIT_COST = 3,
  parameter int unsigned WR_BIT_COST = 7
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic [NRD*CNT_W-1:0] rd_cnt,
  input  logic [NWR*CNT_W-1:0] wr_cnt,
  output logic [ACC_W-1:0]     acc
);
  localparam logic [ACC_W-1:0] MAX_CYC =
    ACC_W'(NRD * WORD_W * RD_BIT_COST + NWR * WORD_W * WR_BIT_COST);

  logic [ACC_W-1:0] cyc_q, cyc_d, acc_q, acc_d;

  always_comb begin
    cyc_d = '0;
    for (int i = 0; i < NRD; i++)
      cyc_d = cyc_d + ACC_W'(rd_cnt[i*CNT_W +: CNT_W]) * ACC_W'(RD_BIT_COST);
    for (int j = 0; j < NWR; j++)
      cyc_d = cyc_d + ACC_W'(wr_cnt[j*CNT_W +: CNT_W]) * ACC_W'(WR_BIT_COST);
    acc_d = acc_q + ACC_W'(BASE_COST) + cyc_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      acc_q <= '0;
    end else begin
      cyc_q <= cyc_d;
      acc_q <= acc_d;
    end
  end

  assign acc = acc_q;

  a_r7_cycle_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    cyc_q <= MAX_CYC);
  a_r2_base_floor: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_ni |=> ((acc_q - $past(acc_q)) >= ACC_W'(BASE_COST)));
endmodule

// File: rtl/rf_toggle_energy_monitor.sv
module rf_toggle_energy_monitor
  import rte_pkg::*;
#(
  parameter int          NRD         = 8,
  parameter int          NWR         = 4,
  parameter int          ACC_W       = 48,
  parameter int unsigned BASE_COST   = 5,
  parameter int unsigned RD_BIT_COST = 3,
  parameter int unsigned WR_BIT_COST = 7
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic [NRD-1:0]        rd_en,
  input  logic [NRD*WORD_W-1:0] rd_data,
  input  logic [NWR-1:0]        wr_en,
  input  logic [NWR*WORD_W-1:0] wr_new,
  input  logic [NWR*WORD_W-1:0] wr_old,
  output logic [ACC_W-1:0]      energy_acc
);
  logic                 rst_n_int;
  logic [NRD*CNT_W-1:0] rd_cnt;
  logic [NWR*CNT_W-1:0] wr_cnt;

  rte_rst_sync u_sync (.clk(clk), .rst_ni(rst_ni), .rst_no(rst_n_int));

  for (genvar i = 0; i < NRD; i++) begin : g_rd
    rte_rd_lane u_lane (
      .clk(clk), .rst_ni(rst_n_int), .en(rd_en[i]),
      .data(rd_data[i*WORD_W +: WORD_W]),
      .cnt(rd_cnt[i*CNT_W +: CNT_W])
    );
  end

  for (genvar j = 0; j < NWR; j++) begin : g_wr
    rte_wr_lane u_lane (
      .clk(clk), .rst_ni(rst_n_int), .en(wr_en[j]),
      .new_w(wr_new[j*WORD_W +: WORD_W]),
      .old_w(wr_old[j*WORD_W +: WORD_W]),
      .cnt(wr_cnt[j*CNT_W +: CNT_W])
    );
  end

  rte_accum #(
    .NRD(NRD), .NWR(NWR), .ACC_W(ACC_W), .BASE_COST(BASE_COST),
    .RD_BIT_COST(RD_BIT_COST), .WR_BIT_COST(WR_BIT_COST)
  ) u_acc (
    .clk(clk), .rst_ni(rst_n_int), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt),
    .acc(energy_acc)
  );

  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n_int |-> (energy_acc == '0));
endmodule

// File: tb/rf_toggle_energy_monitor_test.sv
module rf_toggle_energy_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NRD = 8;
  localparam int NWR = 4;
  localparam int W = 32;
  localparam int ACC_W = 48;
  localparam int BASE = 5;
  localparam int RDC = 3;
  localparam int WRC = 7;

  logic clk = 1'b0;
  logic rst_ni;
  logic [NRD-1:0]   rd_en;
  logic [NRD*W-1:0] rd_data;
  logic [NWR-1:0]   wr_en;
  logic [NWR*W-1:0] wr_new, wr_old;
  logic [ACC_W-1:0] energy_acc;

  int checks = 0;
  int fails = 0;
  logic [ACC_W-1:0] exp_acc;
  longint d1, d2;
  logic [W-1:0] prev_m [NRD];

  always #(CLK_PERIOD/2) clk = ~clk;

  rf_toggle_energy_monitor uut (
    .clk(clk), .rst_ni(rst_ni), .rd_en(rd_en), .rd_data(rd_data),
    .wr_en(wr_en), .wr_new(wr_new), .wr_old(wr_old), .energy_acc(energy_acc)
  );

  task automatic check(string tag, logic [ACC_W-1:0] act, logic [ACC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint model_energy();
    longint e = 0;
    for (int i = 0; i < NRD; i++)
      if (rd_en[i]) begin
        e += RDC * $countones(rd_data[i*W +: W] ^ prev_m[i]);
        prev_m[i] = rd_data[i*W +: W];
      end
    for (int j = 0; j < NWR; j++)
      if (wr_en[j]) e += WRC * $countones(wr_new[j*W +: W] ^ wr_old[j*W +: W]);
    return e;
  endfunction

  task automatic idle();
    rd_en = '0; wr_en = '0; rd_data = '0; wr_new = '0; wr_old = '0;
  endtask

  task automatic step(string tag);
    longint e;
    e = model_energy();
    @(posedge clk);
    exp_acc = exp_acc + ACC_W'(BASE) + ACC_W'(d2);
    d2 = d1;
    d1 = e;
    @(negedge clk);
    check(tag, energy_acc, exp_acc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    idle();
    #1;
    check("R1 async clear", energy_acc, '0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 sync release", energy_acc, '0);
    exp_acc = '0; d1 = 0; d2 = 0;
    for (int i = 0; i < NRD; i++) prev_m[i] = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [ACC_W-1:0] a0;
    void'($urandom(32'h5EED1234));
    rst_ni = 1'b0;
    idle();
    do_reset();

    // R2: idle cycles add only the base cost
    repeat (4) step("R2 idle base");

    // R1 and R3: first read after reset is charged against zero
    rd_en[0] = 1'b1; rd_data[W-1:0] = '1;
    step("R3 first read");
    idle(); rd_data[W-1:0] = '1; rd_en[0] = 1'b1;
    step("R3 repeat read");
    idle();
    repeat (2) step("R3 drain");

    // R4: disabled port with changed data, then enabled with held value
    rd_data[W-1:0] = 32'h0;
    step("R4 disabled read");
    rd_en[0] = 1'b1; rd_data[W-1:0] = '1;
    step("R4 stored word held");
    idle();
    repeat (2) step("R4 drain");

    // R5 and R6: write cost of equal, inverted and disabled writes
    wr_en[1] = 1'b1; wr_new[W +: W] = 32'hA5A5_0F0F; wr_old[W +: W] = 32'hA5A5_0F0F;
    step("R5 equal write");
    wr_old[W +: W] = 32'h5A5A_F0F0;
    step("R5 inverted write");
    wr_en[1] = 1'b0;
    step("R6 disabled write");
    idle();
    repeat (2) step("R6 drain");

    // R8: a single burst of activity shows up exactly two edges later
    a0 = energy_acc;
    rd_en[3] = 1'b1; rd_data[3*W +: W] = 32'h0000_00FF;
    step("R8 edge k");
    idle();
    check("R8 delta k", energy_acc - a0, ACC_W'(BASE));
    a0 = energy_acc;
    step("R8 edge k+1");
    check("R8 delta k+1", energy_acc - a0, ACC_W'(BASE));
    a0 = energy_acc;
    step("R8 edge k+2");
    check("R8 delta k+2", energy_acc - a0, ACC_W'(BASE + 8 * RDC));

    // R7: all ports active at once, top slices included
    rd_en = '1; wr_en = '1;
    for (int i = 0; i < NRD; i++) rd_data[i*W +: W] = 32'hFFFF_0000 ^ i;
    for (int j = 0; j < NWR; j++) begin
      wr_new[j*W +: W] = '1; wr_old[j*W +: W] = '0;
    end
    step("R7 all ports");
    idle();
    repeat (2) step("R7 drain");

    // R7: constrained random mix
    for (int n = 0; n < 300; n++) begin
      rd_en = NRD'($urandom());
      wr_en = NWR'($urandom());
      for (int i = 0; i < NRD; i++)
        rd_data[i*W +: W] = ($urandom() % 4 == 0) ? prev_m[i] : $urandom();
      for (int j = 0; j < NWR; j++) begin
        wr_new[j*W +: W] = $urandom();
        wr_old[j*W +: W] = ($urandom() % 5 == 0) ? wr_new[j*W +: W] : $urandom();
      end
      step("R7 random");
    end

    // R1 and R9: reset in the middle of a run
    do_reset();
    rd_en[7] = 1'b1; rd_data[7*W +: W] = 32'h8000_0001;
    step("R1 zero after reset");
    idle();
    repeat (2) step("R1 drain");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule